// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block keeps a small set of recently used virtual-to-physical page translations in a content-addressed store. A lookup gives a virtual address, the access kind (read or write) and the privilege level. Every valid entry compares its stored virtual page number against the request in the same cycle. When an entry matches and the access is allowed, the block returns the physical address in that cycle, combinationally. The physical address is the stored physical page number in front of the unchanged page offset. A matching entry that does not allow the access raises a protection fault and returns no address. When no entry matches, the block reports a miss and leaves the page table walk to the requester.

A separate refill port lets the walker install a translation with its permission bits. A new page goes into the slot named by a first-in first-out pointer. A refill for a page that is already present rewrites that entry in place, so no page is ever held twice. A flush input drops every translation in one cycle. A write that hits a clean page marks the page dirty, and a lookup hit reports the page's dirty state so the requester can see it. With the default 64 entries and 4 KB pages, the buffer maps 256 KB of virtual space.

Top module: `page_xlate_tlb`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports miss with hit and protFault low and paddr zero.
- R2: A permitted lookup that matches a valid entry raises hit in the same cycle and drives paddr = {stored PPN, vaddr[11:0]}.
- R3: A lookup whose page number (vaddr[31:12]) matches no valid entry raises miss, keeps hit and protFault low, and drives paddr to zero.
- R4: A read (lookupWrite=0) that matches an entry whose read permission is clear raises protFault, with hit low and paddr zero.
- R5: A write (lookupWrite=1) that matches an entry whose write permission is clear raises protFault, with hit low and paddr zero.
- R6: A user-mode lookup (lookupUser=1) that matches an entry whose user bit is clear faults. A kernel-mode lookup ignores the user bit and still applies the read and write permissions.
- R7: lookupDirty gives the matched entry's dirty bit on a hit. A write hit to a clean entry makes later hits on that entry report dirty. A faulting write leaves the bit unchanged.
- R8: A refill of a page not yet present goes into the slot at the FIFO pointer, which then advances and wraps after DEPTH-1. Once all DEPTH slots are full, the next new page evicts the oldest one.
- R9: A refill whose page is already present rewrites that entry's PPN and flags in place and does not move the FIFO pointer.
- R10: A flush invalidates every entry in one cycle and returns the FIFO pointer to slot zero.
- R11: When flush and refillValid are high in the same cycle, the flush wins and the refill is discarded.
- R12: With lookupValid low, hit, miss and protFault are all low. At most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | A translation request is present |
| lookupVaddr | input | 32 | Virtual address to translate |
| lookupWrite | input | 1 | 1 = write access, 0 = read access |
| lookupUser | input | 1 | 1 = user mode, 0 = kernel mode |
| flush | input | 1 | Invalidate all entries, reset FIFO pointer |
| refillValid | input | 1 | Install a translation this cycle |
| refillVpn | input | 20 | Virtual page number to install |
| refillPpn | input | 20 | Physical page number to install |
| refillRead | input | 1 | Read permission of the new entry |
| refillWrite | input | 1 | Write permission of the new entry |
| refillUser | input | 1 | User-accessible bit of the new entry |
| refillDirty | input | 1 | Initial dirty bit of the new entry |
| hit | output | 1 | Permitted translation found |
| miss | output | 1 | No valid entry for the page |
| protFault | output | 1 | Entry found but access is not permitted |
| lookupDirty | output | 1 | Dirty bit of the matched entry, valid on hit |
| paddr | output | 32 | Translated physical address, zero unless hit |

## Verification
The hardest case to reach from the ports is FIFO wrap-around and eviction. Only refills of new pages move the pointer, so the stimulus first flushes, which also shows that the pointer returns to zero. It then refills 64 distinct pages and puts in one duplicate refill. The next new page must then evict the page loaded first, not the one loaded second. The dirty update is a second such case: it can only be seen one lookup later, so a write hit is followed by a read hit that must report dirty, and a faulting write is followed by a read that must still report clean.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Widest index the block supports (DEPTH up to 128).
  localparam int IDX_MAX_W = 7;

  // Strobes from the control unit to the entry array.
  typedef struct packed {
    logic                 clearAll;
    logic                 fillEn;
    logic [IDX_MAX_W-1:0] fillIdx;
    logic                 dirtyEn;
    logic [IDX_MAX_W-1:0] dirtyIdx;
  } tlbStrobes_t;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tlbStrobes_t       strobes,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PPN_W-1:0]  fillPpn,
  input  logic              fillRead,
  input  logic              fillWrite,
  input  logic              fillUser,
  input  logic              fillDirty,
  input  logic [VPN_W-1:0]  lookupVpn,
  output logic              lkFound,
  output logic [IDX_W-1:0]  lkIdx,
  output logic              lkRead,
  output logic              lkWrite,
  output logic              lkUser,
  output logic              lkDirty,
  output logic [PPN_W-1:0]  lkPpn,
  output logic              rfFound,
  output logic [IDX_W-1:0]  rfIdx
);

  logic [DEPTH-1:0] validVec, readVec, writeVec, userVec, dirtyVec;
  logic [DEPTH-1:0] lkMatch, rfMatch;
  logic [PPN_W-1:0] ppnArr [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic             vld, rdOk, wrOk, usrOk, dty;
    logic [VPN_W-1:0] tag;
    logic [PPN_W-1:0] ppn;
    logic             fillThis, dirtyThis;

    assign fillThis  = strobes.fillEn  && (strobes.fillIdx  == IDX_MAX_W'(e));
    assign dirtyThis = strobes.dirtyEn && (strobes.dirtyIdx == IDX_MAX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld   <= 1'b0;
        rdOk  <= 1'b0;
        wrOk  <= 1'b0;
        usrOk <= 1'b0;
        dty   <= 1'b0;
        tag   <= '0;
        ppn   <= '0;
      end else if (strobes.clearAll) begin
        vld <= 1'b0;
      end else if (fillThis) begin
        vld   <= 1'b1;
        rdOk  <= fillRead;
        wrOk  <= fillWrite;
        usrOk <= fillUser;
        dty   <= fillDirty;
        tag   <= fillVpn;
        ppn   <= fillPpn;
      end else if (dirtyThis) begin
        dty <= 1'b1;
      end
    end

    assign validVec[e] = vld;
    assign readVec[e]  = rdOk;
    assign writeVec[e] = wrOk;
    assign userVec[e]  = usrOk;
    assign dirtyVec[e] = dty;
    assign ppnArr[e]   = ppn;
    assign lkMatch[e]  = vld && (tag == lookupVpn);
    assign rfMatch[e]  = vld && (tag == fillVpn);
  end

  // Lowest-indexed match wins.
  always_comb begin
    lkIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (lkMatch[i]) lkIdx = IDX_W'(i);
    end
  end

  always_comb begin
    rfIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (rfMatch[i]) rfIdx = IDX_W'(i);
    end
  end

  assign lkFound = |lkMatch;
  assign rfFound = |rfMatch;
  assign lkRead  = readVec[lkIdx];
  assign lkWrite = writeVec[lkIdx];
  assign lkUser  = userVec[lkIdx];
  assign lkDirty = dirtyVec[lkIdx];
  assign lkPpn   = ppnArr[lkIdx];

  // R10: a clear strobe leaves no valid entry behind
  p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clearAll |=> (validVec == '0));

  // R7: a dirty strobe not overridden by clear or fill sets the bit
  p_dirty_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.dirtyEn && !strobes.clearAll &&
     !(strobes.fillEn && strobes.fillIdx == strobes.dirtyIdx))
    |=> dirtyVec[$past(strobes.dirtyIdx)]);

endmodule

// File: rtl/tlb_control.sv
module tlb_control
  import tlb_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lookupValid,
  input  logic             lookupWrite,
  input  logic             lookupUser,
  input  logic             flush,
  input  logic             refillValid,
  input  logic             lkFound,
  input  logic [IDX_W-1:0] lkIdx,
  input  logic             lkRead,
  input  logic             lkWrite,
  input  logic             lkUser,
  input  logic             lkDirty,
  input  logic             rfFound,
  input  logic [IDX_W-1:0] rfIdx,
  output tlbStrobes_t      strobes,
  output logic             hit,
  output logic             miss,
  output logic             protFault
);

  logic [IDX_W-1:0] fifoPtr;
  logic             permitted;
  logic             fillDo;

  assign permitted = (lookupWrite ? lkWrite : lkRead) && (!lookupUser || lkUser);
  assign hit       = lookupValid && lkFound && permitted;
  assign protFault = lookupValid && lkFound && !permitted;
  assign miss      = lookupValid && !lkFound;
  assign fillDo    = refillValid && !flush;

  always_comb begin
    strobes          = '0;
    strobes.clearAll = flush;
    strobes.fillEn   = fillDo;
    strobes.fillIdx  = IDX_MAX_W'(rfFound ? rfIdx : fifoPtr);
    strobes.dirtyEn  = hit && lookupWrite && !lkDirty;
    strobes.dirtyIdx = IDX_MAX_W'(lkIdx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifoPtr <= '0;
    end else if (flush) begin
      fifoPtr <= '0;
    end else if (fillDo && !rfFound) begin
      fifoPtr <= (fifoPtr == IDX_W'(DEPTH - 1)) ? '0 : fifoPtr + 1'b1;
    end
  end

  // R12: outcome flags are exclusive
  p_outcome_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, miss, protFault}));

  // R12: no outcome without a request
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !lookupValid |-> !(hit || miss || protFault));

  // R10: flush returns the pointer to zero
  p_ptr_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fifoPtr == '0));

  // R9: an in-place refill keeps the pointer
  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (refillValid && rfFound && !flush) |=> $stable(fifoPtr));

  // R7: a faulting access never requests a dirty update
  p_fault_no_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    protFault |-> !strobes.dirtyEn);

endmodule

// File: rtl/page_xlate_tlb.sv
module page_xlate_tlb
  import tlb_pkg::*;
#(
  parameter int VADDR_W  = 32,
  parameter int PADDR_W  = 32,
  parameter int OFFSET_W = 12,
  parameter int DEPTH    = 64,
  localparam int VPN_W = VADDR_W - OFFSET_W,
  localparam int PPN_W = PADDR_W - OFFSET_W,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lookupValid,
  input  logic [VADDR_W-1:0] lookupVaddr,
  input  logic               lookupWrite,
  input  logic               lookupUser,
  input  logic               flush,
  input  logic               refillValid,
  input  logic [VPN_W-1:0]   refillVpn,
  input  logic [PPN_W-1:0]   refillPpn,
  input  logic               refillRead,
  input  logic               refillWrite,
  input  logic               refillUser,
  input  logic               refillDirty,
  output logic               hit,
  output logic               miss,
  output logic               protFault,
  output logic               lookupDirty,
  output logic [PADDR_W-1:0] paddr
);

  tlbStrobes_t      strobes;
  logic             lkFound, lkRead, lkWrite, lkUser, lkDirty, rfFound;
  logic [IDX_W-1:0] lkIdx, rfIdx;
  logic [PPN_W-1:0] lkPpn;

  tlb_entry_array #(.DEPTH(DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .fillVpn   (refillVpn),
    .fillPpn   (refillPpn),
    .fillRead  (refillRead),
    .fillWrite (refillWrite),
    .fillUser  (refillUser),
    .fillDirty (refillDirty),
    .lookupVpn (lookupVaddr[VADDR_W-1:OFFSET_W]),
    .lkFound   (lkFound),
    .lkIdx     (lkIdx),
    .lkRead    (lkRead),
    .lkWrite   (lkWrite),
    .lkUser    (lkUser),
    .lkDirty   (lkDirty),
    .lkPpn     (lkPpn),
    .rfFound   (rfFound),
    .rfIdx     (rfIdx)
  );

  tlb_control #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .lookupValid (lookupValid),
    .lookupWrite (lookupWrite),
    .lookupUser  (lookupUser),
    .flush       (flush),
    .refillValid (refillValid),
    .lkFound     (lkFound),
    .lkIdx       (lkIdx),
    .lkRead      (lkRead),
    .lkWrite     (lkWrite),
    .lkUser      (lkUser),
    .lkDirty     (lkDirty),
    .rfFound     (rfFound),
    .rfIdx       (rfIdx),
    .strobes     (strobes),
    .hit         (hit),
    .miss        (miss),
    .protFault   (protFault)
  );

  assign paddr       = hit ? {lkPpn, lookupVaddr[OFFSET_W-1:0]} : '0;
  assign lookupDirty = hit && lkDirty;

  // R2: the page offset passes through untouched on a hit
  p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (paddr[OFFSET_W-1:0] == lookupVaddr[OFFSET_W-1:0]));

  // R4/R5/R6: a fault returns no address
  p_fault_no_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    protFault |-> (paddr == '0));

endmodule

// File: tb/page_xlate_tlb_test.sv
module page_xlate_tlb_test;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupVaddr = '0;
  logic        lookupWrite = 1'b0;
  logic        lookupUser = 1'b0;
  logic        flush = 1'b0;
  logic        refillValid = 1'b0;
  logic [19:0] refillVpn = '0;
  logic [19:0] refillPpn = '0;
  logic        refillRead = 1'b0;
  logic        refillWrite = 1'b0;
  logic        refillUser = 1'b0;
  logic        refillDirty = 1'b0;
  logic        hit, miss, protFault, lookupDirty;
  logic [31:0] paddr;

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  // sampled results
  logic        sHit, sMiss, sFault, sDirty;
  logic [31:0] sPaddr;

  always #5 clk = ~clk;

  page_xlate_tlb uut (
    .clk(clk), .rst_n(rst_n), .lookupValid(lookupValid), .lookupVaddr(lookupVaddr),
    .lookupWrite(lookupWrite), .lookupUser(lookupUser), .flush(flush),
    .refillValid(refillValid), .refillVpn(refillVpn), .refillPpn(refillPpn),
    .refillRead(refillRead), .refillWrite(refillWrite), .refillUser(refillUser),
    .refillDirty(refillDirty), .hit(hit), .miss(miss), .protFault(protFault),
    .lookupDirty(lookupDirty), .paddr(paddr)
  );

  task automatic check(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic refill(input logic [19:0] vpn, input logic [19:0] ppn,
                        input logic r, input logic w, input logic u, input logic d);
    @(negedge clk);
    refillValid = 1'b1; refillVpn = vpn; refillPpn = ppn;
    refillRead = r; refillWrite = w; refillUser = u; refillDirty = d;
    @(posedge clk); #1;
    refillValid = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic wr, input logic usr);
    @(negedge clk);
    lookupValid = 1'b1; lookupVaddr = va; lookupWrite = wr; lookupUser = usr;
    #1;
    sHit = hit; sMiss = miss; sFault = protFault; sDirty = lookupDirty; sPaddr = paddr;
    @(posedge clk); #1;
    lookupValid = 1'b0;
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk); #1;
    flush = 1'b0;
  endtask

  task automatic expectHit(input string req, input logic [31:0] va, input logic wr,
                           input logic usr, input logic [31:0] pa);
    lookup(va, wr, usr);
    check(req, sHit && !sMiss && !sFault, {29'd0, sHit, sMiss, sFault}, 32'h4);
    check(req, sPaddr == pa, sPaddr, pa);
  endtask

  task automatic expectMiss(input string req, input logic [31:0] va);
    lookup(va, 1'b0, 1'b0);
    check(req, sMiss && !sHit && !sFault && sPaddr == 0, {29'd0, sHit, sMiss, sFault}, 32'h2);
  endtask

  task automatic expectFault(input string req, input logic [31:0] va, input logic wr, input logic usr);
    lookup(va, wr, usr);
    check(req, sFault && !sHit && !sMiss && sPaddr == 0, {29'd0, sHit, sMiss, sFault}, 32'h1);
  endtask

  // R1
  task automatic testReset();
    expectMiss("R1 reset miss", 32'h1234_5678);
    expectMiss("R1 reset miss zero page", 32'h0000_0000);
  endtask

  // R2, R3
  task automatic testBasic();
    refill(20'h00010, 20'hABCDE, 1, 1, 1, 0);
    expectHit("R2 read hit", 32'h0001_0123, 1'b0, 1'b1, 32'hABCD_E123);
    expectHit("R2 offset fff", 32'h0001_0FFF, 1'b0, 1'b0, 32'hABCD_EFFF);
    expectMiss("R3 miss neighbour page", 32'h0001_1123);
  endtask

  // R4, R5, R6
  task automatic testPerms();
    refill(20'h00020, 20'h11111, 0, 1, 1, 0);
    refill(20'h00021, 20'h22222, 1, 0, 1, 0);
    refill(20'h00022, 20'h33333, 1, 1, 0, 0);
    expectFault("R4 read without read perm", 32'h0002_0004, 1'b0, 1'b1);
    expectHit("R4 write allowed", 32'h0002_0008, 1'b1, 1'b1, 32'h1111_1008);
    expectFault("R5 write without write perm", 32'h0002_1010, 1'b1, 1'b0);
    expectFault("R6 user on kernel page", 32'h0002_2020, 1'b0, 1'b1);
    expectHit("R6 kernel on kernel page", 32'h0002_2020, 1'b0, 1'b0, 32'h3333_3020);
    expectFault("R6 kernel still needs write perm", 32'h0002_1000, 1'b1, 1'b0);
  endtask

  // R7
  task automatic testDirty();
    refill(20'h00030, 20'h44444, 1, 1, 1, 0);
    lookup(32'h0003_0000, 1'b0, 1'b1);
    check("R7 clean before write", sHit && !sDirty, {31'd0, sDirty}, 32'd0);
    lookup(32'h0003_0004, 1'b1, 1'b1);
    check("R7 write hit reports old clean", sHit && !sDirty, {31'd0, sDirty}, 32'd0);
    lookup(32'h0003_0000, 1'b0, 1'b1);
    check("R7 dirty after write", sHit && sDirty, {31'd0, sDirty}, 32'd1);
    expectFault("R7 faulting write", 32'h0002_1000, 1'b1, 1'b1);
    lookup(32'h0002_1000, 1'b0, 1'b1);
    check("R7 fault left clean", sHit && !sDirty, {31'd0, sDirty}, 32'd0);
  endtask

  // R12
  task automatic testIdle();
    @(negedge clk);
    lookupValid = 1'b0; lookupVaddr = 32'h0001_0000;
    #1;
    check("R12 idle quiet", !hit && !miss && !protFault,
          {29'd0, hit, miss, protFault}, 32'd0);
  endtask

  // R10, R8, R9
  task automatic testFifo();
    doFlush();
    expectMiss("R10 flushed entry gone", 32'h0001_0000);
    for (int i = 0; i < DEPTH; i++) refill(20'h00100 + 20'(i), 20'(i), 1, 1, 1, 0);
    expectHit("R8 first loaded present", 32'h0010_0000, 1'b0, 1'b0, 32'h0000_0000);
    expectHit("R8 last loaded present", 32'h0013_F000, 1'b0, 1'b0, 32'h0003_F000);
    refill(20'h00100, 20'h00777, 1, 1, 1, 0);
    expectHit("R9 in-place rewrite", 32'h0010_0ABC, 1'b0, 1'b0, 32'h0077_7ABC);
    refill(20'h00200, 20'h00888, 1, 1, 1, 0);
    expectMiss("R8 oldest evicted (R9 pointer held, R10 pointer zero)", 32'h0010_0000);
    expectHit("R8 second oldest kept", 32'h0010_1000, 1'b0, 1'b0, 32'h0000_1000);
    expectHit("R8 new page present", 32'h0020_0010, 1'b0, 1'b0, 32'h0088_8010);
  endtask

  // R11
  task automatic testFlushWins();
    @(negedge clk);
    flush = 1'b1; refillValid = 1'b1; refillVpn = 20'h00300; refillPpn = 20'h00999;
    refillRead = 1; refillWrite = 1; refillUser = 1; refillDirty = 0;
    @(posedge clk); #1;
    flush = 1'b0; refillValid = 1'b0;
    expectMiss("R11 refill dropped under flush", 32'h0030_0000);
    expectMiss("R11 older entry flushed", 32'h0020_0000);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    testReset();
    testBasic();
    testPerms();
    testDirty();
    testIdle();
    testFifo();
    testFlushWins();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule